// File: doc/BRIEF.md
# Per-CPU Private Countdown Timer

This block is a 32-bit timer that counts down from a programmed value and flags an interrupt when it runs out. Software programs it through four word registers on a plain synchronous register bus: a reload value, the live count, a control word and a sticky status flag. The control word switches the timer on, chooses between one-shot and periodic operation, and sets an 8-bit prescaler. The prescaler slows the count rate to one step every (prescaler + 1) clock cycles.

When the count steps from one to zero, the status flag is set. A level interrupt output follows this flag. In periodic mode the count is refilled from the reload value and keeps running. In one-shot mode it stays at zero and stops. Software acknowledges the interrupt by writing a one to bit 0 of the status register. A zero count never produces an expiry. When the enable bit rises while the count is zero and periodic mode is selected, the reload value is pulled into the count.

Top module: `pvt_countdown_timer`

## Requirements
- R1: After reset the load, counter, control and status registers all read as zero and `irq` is low.
- R2: Registers sit at byte offsets 0x0 (load), 0x4 (counter), 0x8 (control) and 0xC (status). Every other offset reads as zero, and a write to it changes no register.
- R3: Writing the load register stores the data both as the reload value and as the live count.
- R4: In the control word, bit 0 is enable, bit 1 is periodic (auto-reload) and bits [15:8] are the prescaler. A control read returns exactly these bits, with all other bits zero.
- R5: While enabled with a non-zero count, the count drops by one every (prescaler + 1) cycles. The first step comes (prescaler + 1) cycles after the enabling write or a counter write.
- R6: The step from one to zero sets status bit 0, and `irq` is high whenever that bit is set.
- R7: In periodic mode the expiring step loads the reload value, and counting continues with the same period.
- R8: In one-shot mode the count stays at zero after expiry, and the status flag stays set.
- R9: A zero count never expires, including a periodic enable with a zero reload value.
- R10: A 0-to-1 change of enable, with the count at zero and periodic mode set in the same write, first copies the reload value into the count.
- R11: The counter reads as zero while enable is clear. The held count is kept and resumes when the timer is enabled again.
- R12: A write to the status register clears bit 0 only when write-data bit 0 is one. A write with bit 0 zero leaves the flag unchanged.
- R13: A counter write while running takes effect at once, and counting resumes from the new value after a full prescaler period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt, equal to status bit 0 |

## Verification
The hardest cases to reach are those where the periodic refill and the enable-edge refill act on a count that was forced to zero behind the reload value. To get there, the stimulus loads a value, writes the counter back to zero, and only then raises enable with periodic mode set. It then samples the count and the flag on exact cycle offsets from the enabling write, across two consecutive expiries. Prescaled timing is checked by reading the count one cycle before and one cycle after the expected step edges.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_LOAD  = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_STAT  = 3'd4
  } reg_sel_e;

  localparam int unsigned OFS_LOAD  = 32'h0;
  localparam int unsigned OFS_COUNT = 32'h4;
  localparam int unsigned OFS_CTRL  = 32'h8;
  localparam int unsigned OFS_STAT  = 32'hC;

  // Map a byte offset to the register it selects.
  function automatic reg_sel_e decode_offset(input int unsigned ofs);
    case (ofs)
      OFS_LOAD:  return SEL_LOAD;
      OFS_COUNT: return SEL_COUNT;
      OFS_CTRL:  return SEL_CTRL;
      OFS_STAT:  return SEL_STAT;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output logic              wr_load,
  output logic              wr_count,
  output logic              wr_ctrl,
  output logic              wr_stat
);

  always_comb begin
    sel      = decode_offset(32'(addr));
    wr_load  = we && (sel == SEL_LOAD);
    wr_count = we && (sel == SEL_COUNT);
    wr_ctrl  = we && (sel == SEL_CTRL);
    wr_stat  = we && (sel == SEL_STAT);
  end

endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);

  logic [PRE_W-1:0] div_q;

  // A tick ends each window of (limit + 1) running cycles.
  assign tick = run && (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart || !run || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R5: with a non-zero limit, two ticks never come back to back
  a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (limit != '0) && $stable(limit)) |=> !tick);

  // R5: a restart opens a fresh window
  a_r5_restart_window: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (limit != '0)) |=> !tick);

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic              wr_count,
  input  logic [DATA_W-1:0] wdata,
  input  logic              enable,
  input  logic              reload,
  input  logic              fill,
  input  logic              tick,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] load_q,
  output logic              running,
  output logic              expire
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  // Count after one step: the refill value on expiry, otherwise one less.
  function automatic logic [DATA_W-1:0] next_step(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] refill,
    input logic              periodic
  );
    if (cur == ONE) return periodic ? refill : '0;
    return cur - ONE;
  endfunction

  logic bus_touch;
  assign bus_touch = wr_load || wr_count;
  assign running   = enable && (count_q != '0);
  assign expire    = running && tick && !bus_touch && (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_load) begin
        load_q  <= wdata;
        count_q <= wdata;
      end else if (wr_count) begin
        count_q <= wdata;
      end else if (fill) begin
        count_q <= load_q;
      end else if (running && tick) begin
        count_q <= next_step(count_q, load_q, reload);
      end
    end
  end

  // R5: an ordinary tick removes exactly one
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !bus_touch && (count_q > ONE)) |=> (count_q == $past(count_q) - ONE));

  // R7: periodic expiry refills from the reload value
  a_r7_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload) |=> (count_q == $past(load_q)));

  // R8: one-shot expiry parks at zero
  a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload) |=> (count_q == '0));

  // R11: with enable clear and no bus change, the count holds
  a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !bus_touch && !fill) |=> $stable(count_q));

  // R3: a load write lands in both registers
  a_r3_load_both: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> ((count_q == load_q) && (load_q == $past(wdata))));

endmodule

// File: rtl/pvt_countdown_timer.sv
module pvt_countdown_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int PRE_W   = 8,
  parameter int PRE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int EN_BIT = 0;
  localparam int RL_BIT = 1;

  reg_sel_e          sel;
  logic              wr_load, wr_count, wr_ctrl, wr_stat;
  logic              en_q, rl_q;
  logic [PRE_W-1:0]  pre_q;
  logic              stat_q;
  logic [DATA_W-1:0] count_q, load_q;
  logic              running, expire, tick;
  logic              en_rise, fill, pre_restart;

  cdt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (bus_addr),
    .we      (bus_we),
    .sel     (sel),
    .wr_load (wr_load),
    .wr_count(wr_count),
    .wr_ctrl (wr_ctrl),
    .wr_stat (wr_stat)
  );

  assign en_rise     = wr_ctrl && bus_wdata[EN_BIT] && !en_q;
  assign fill        = en_rise && bus_wdata[RL_BIT] && (count_q == '0);
  assign pre_restart = wr_load || wr_count || en_rise;

  cdt_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (running),
    .restart(pre_restart),
    .limit  (pre_q),
    .tick   (tick)
  );

  cdt_counter #(.DATA_W(DATA_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_load (wr_load),
    .wr_count(wr_count),
    .wdata   (bus_wdata),
    .enable  (en_q),
    .reload  (rl_q),
    .fill    (fill),
    .tick    (tick),
    .count_q (count_q),
    .load_q  (load_q),
    .running (running),
    .expire  (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rl_q  <= 1'b0;
      pre_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= bus_wdata[EN_BIT];
      rl_q  <= bus_wdata[RL_BIT];
      pre_q <= bus_wdata[PRE_LSB +: PRE_W];
    end
  end

  // Expiry outranks a same-cycle acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (expire) begin
      stat_q <= 1'b1;
    end else if (wr_stat && bus_wdata[0]) begin
      stat_q <= 1'b0;
    end
  end

  assign irq = stat_q;

  // The visible count is zero whenever the timer is off.
  function automatic logic [DATA_W-1:0] count_view(
    input logic              on,
    input logic [DATA_W-1:0] cur
  );
    return on ? cur : '0;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_view(
    input logic             on,
    input logic             periodic,
    input logic [PRE_W-1:0] pre
  );
    logic [DATA_W-1:0] v;
    v = '0;
    v[EN_BIT] = on;
    v[RL_BIT] = periodic;
    v[PRE_LSB +: PRE_W] = pre;
    return v;
  endfunction

  always_comb begin
    case (sel)
      SEL_LOAD:  bus_rdata = load_q;
      SEL_COUNT: bus_rdata = count_view(en_q, count_q);
      SEL_CTRL:  bus_rdata = ctrl_view(en_q, rl_q, pre_q);
      SEL_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, stat_q};
      default:   bus_rdata = '0;
    endcase
  end

  // R6: an expiry raises the interrupt on the next cycle
  a_r6_irq_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);

  // R12: an acknowledge with bit 0 set and no expiry drops the interrupt
  a_r12_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !expire) |=> !irq);

  // R12: an acknowledge with bit 0 clear leaves the flag
  a_r12_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[0]) |=> (irq || !$past(irq)));

  // R11: a counter read with the timer off returns zero
  a_r11_read_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == SEL_COUNT) && !en_q) |-> (bus_rdata == '0));

  // R2: unmapped offsets read zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/pvt_countdown_timer_bench.sv
module pvt_countdown_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic rd_v = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [4:0] A_LOAD = 5'h0, A_CNT = 5'h4, A_CTL = 5'h8, A_STS = 5'hC;

  always #4 clk = ~clk;

  pvt_countdown_timer u_pvt_countdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Monitor: pops expected read data and compares mid-cycle.
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (rd_v && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_v = 1'b1;
    @(negedge clk); #1;
    rd_v = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq %b expected %b", t, irq, e);
    end
  endtask

  // Count left after some edges in one-shot mode.
  function automatic logic [31:0] left_after(input int n, input int pre, input int edges);
    int r;
    r = n - edges / (pre + 1);
    return (r < 0) ? 32'd0 : 32'(r);
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(A_LOAD, 0, "R1 load");
    rd(A_CNT, 0, "R1 counter");
    rd(A_CTL, 0, "R1 control");
    rd(A_STS, 0, "R1 status");
    chk_irq(1'b0, "R1 irq");

    // R3 load write, R11 view while off, R5 first step
    wr(A_LOAD, 32'd100);
    rd(A_LOAD, 32'd100, "R3 load value");
    rd(A_CNT, 0, "R11 counter reads zero while off");
    wr(A_CTL, 32'h1);
    rd(A_CNT, left_after(100, 0, 1), "R3 counter took load value");

    // R5 prescaler 3
    wr(A_CTL, 32'h0);
    wr(A_CNT, 32'd50);
    wr(A_CTL, 32'h0301);
    idle(7);
    rd(A_CNT, left_after(50, 3, 8), "R5 prescaled count");

    // R6/R8 one-shot expiry, prescaler 1, count 5: expires 10 edges after enable
    wr(A_CTL, 32'h0);
    wr(A_LOAD, 32'd5);
    wr(A_CTL, 32'h0101);
    idle(7);
    rd(A_CNT, left_after(5, 1, 8), "R5 count before expiry");
    rd(A_STS, 0, "R6 status clear one edge early");
    rd(A_STS, 1, "R6 status set at expiry");
    chk_irq(1'b1, "R6 irq follows status");
    rd(A_CNT, 0, "R8 count parked at zero");
    idle(20);
    rd(A_CNT, 0, "R8 count still zero");
    rd(A_STS, 1, "R8 status stays set");

    // R12 write-one-to-clear
    wr(A_STS, 32'h0);
    rd(A_STS, 1, "R12 zero write keeps flag");
    wr(A_STS, 32'h1);
    rd(A_STS, 0, "R12 one write clears flag");
    chk_irq(1'b0, "R12 irq low after clear");

    // R9 zero count never expires
    wr(A_CNT, 32'd0);
    idle(10);
    rd(A_STS, 0, "R9 zero count while enabled");
    wr(A_CTL, 32'h0);
    wr(A_LOAD, 32'd0);
    wr(A_CTL, 32'h3);
    idle(10);
    rd(A_STS, 0, "R9 periodic with zero reload");
    rd(A_CNT, 0, "R9 count stays zero");

    // R10 enable edge fills from load, then R7 periodic
    wr(A_CTL, 32'h0);
    wr(A_LOAD, 32'd7);
    wr(A_CNT, 32'd0);
    wr(A_CTL, 32'h3);
    rd(A_CNT, 32'd6, "R10 fill from load on enable");
    idle(4);
    rd(A_STS, 0, "R7 no flag before first expiry");
    rd(A_STS, 1, "R7 flag at first expiry");
    rd(A_CNT, 32'd6, "R7 refilled and counting");
    wr(A_STS, 32'h1);
    rd(A_CNT, 32'd3, "R7 continues after refill");
    idle(1);
    rd(A_STS, 0, "R7 no flag before second expiry");
    rd(A_STS, 1, "R7 second expiry after full period");
    rd(A_CNT, 32'd6, "R7 second refill");

    // R13 counter write while running
    wr(A_CNT, 32'd20);
    rd(A_CNT, 32'd19, "R13 resumes from new value");

    // R2 unmapped offsets
    wr(5'h10, 32'hDEAD_BEEF);
    wr(5'h2, 32'h55);
    rd(A_LOAD, 32'd7, "R2 unmapped write leaves load");
    rd(5'h10, 0, "R2 offset 0x10 reads zero");
    rd(5'h2, 0, "R2 offset 0x2 reads zero");

    // R4 control field layout
    wr(A_CTL, 32'hFFFF_FFFC);
    rd(A_CTL, 32'h0000_FF00, "R4 only prescaler kept");
    wr(A_CTL, 32'h0000_AB02);
    rd(A_CTL, 32'h0000_AB02, "R4 reload and prescaler bits");

    // R11 held count resumes
    wr(A_CTL, 32'h0);
    wr(A_CNT, 32'd30);
    rd(A_CNT, 0, "R11 off reads zero");
    wr(A_CTL, 32'h1);
    rd(A_CNT, 32'd29, "R11 held count resumes");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule